// File: doc/BRIEF.md
# UART Receive/Transmit Request Generator

This block sits next to a UART's receive and transmit paths and turns their FIFO occupancy, transfer strobes and receive error flags into request pulses. Each direction has a 2-bit mode field. The field either routes the request to an interrupt line, routes it to a DMA request line, or suppresses it. With FIFOs enabled, a receive request fires when a newly stored word brings the occupancy up to a programmable threshold. A receive request also fires after three silent word times while a few words wait below that threshold. A transmit request fires when a word leaving the transmit FIFO brings the remaining count down to its threshold. With FIFOs disabled, the single holding register on each side drives the requests directly.

The four receive error conditions are overrun, parity, frame and break. They collect into sticky status bits, and a status read clears them. Any new error raises one error-interrupt pulse when errors are enabled. The status output also reports three live flags: receive data present, transmit buffer empty and transmit shifter empty. All outputs are registered, so every response appears on the clock edge after the stimulus.

Top module: `uirq_irq_gen`

## Requirements
- R1: While reset is asserted, every output is 0.
- R2: One cycle after the inputs are sampled, stat[4] is 1 when rx_level is nonzero, stat[5] is 1 when tx_level is zero, and stat[6] follows tx_shift_empty.
- R3: The sticky error bits are stat[0] overrun, stat[1] parity, stat[2] frame and stat[3] break. Each bit is set by its condition and holds until a cycle with err_rd high. In that cycle the bits are replaced by only the conditions present in that same cycle.
- R4: Overrun is detected when rx_push arrives while rx_level equals the capacity. The capacity is DEPTH with FIFOs on and 1 with FIFOs off.
- R5: err_irq pulses for one cycle after any cycle that has at least one error condition while err_ie is 1. Simultaneous errors give a single pulse, and no pulse occurs while err_ie is 0.
- R6: With fifo_en=1, a receive request occurs when rx_push arrives and rx_level+1 equals the threshold. rx_trig codes 0,1,2,3 select 1, DEPTH/4, DEPTH/2 and 3*DEPTH/4 entries.
- R7: With fifo_en=1, a receive request also occurs once the FIFO has been nonempty and below the threshold for 3*(WORD_BASE+word_len) bit_tick pulses with no rx_push. It fires once, and the count restarts on rx_push or when rx_level is 0.
- R8: With fifo_en=0, every rx_push produces a receive request.
- R9: With fifo_en=1, a transmit request occurs when tx_pop arrives with tx_level nonzero and tx_level-1 equal to the tx_trig threshold (same code table as R6).
- R10: With fifo_en=0, every tx_pop produces a transmit request.
- R11: Mode code 01 sends a request to the interrupt line and code 10 sends it to the DMA line. Codes 00 and 11 drop it. Each request is a one-cycle pulse one cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rx_mode | input | 2 | Receive request routing (01 irq, 10 DMA) |
| tx_mode | input | 2 | Transmit request routing (01 irq, 10 DMA) |
| rx_trig | input | 2 | Receive threshold code |
| tx_trig | input | 2 | Transmit threshold code |
| word_len | input | 2 | Data bits minus 5 |
| err_ie | input | 1 | Error interrupt enable |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_push | input | 1 | Receive shifter stores a word |
| rx_level | input | CW | Receive occupancy before this cycle's push |
| par_err | input | 1 | Parity error strobe |
| frm_err | input | 1 | Frame error strobe |
| brk_det | input | 1 | Break detect strobe |
| tx_pop | input | 1 | Word moves to transmit shifter |
| tx_level | input | CW | Transmit occupancy before this cycle's pop |
| tx_shift_empty | input | 1 | Transmit shifter idle |
| err_rd | input | 1 | Error status read strobe (clears) |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| rx_dma | output | 1 | Receive DMA request pulse |
| tx_dma | output | 1 | Transmit DMA request pulse |
| stat | output | 7 | Status: errors [3:0], rx data [4], tx empty [5], shifter empty [6] |

## Verification
The bench uses the defaults DEPTH=16 and WORD_BASE=7. These give thresholds of 1, 4, 8 and 12 entries, so a full FIFO and its overrun are reached within a few dozen pushes. Timeout windows are 21 to 30 bit ticks, so quiet phases with sparse pushes reach and re-arm the timeout many times. Mode and threshold codes are redrawn per phase, including the two dropping mode codes and non-FIFO operation.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_IRQ = 2'b01,
        MODE_DMA = 2'b10,
        MODE_RSV = 2'b11
    } req_mode_e;

    typedef struct packed {
        logic       rx_irq;
        logic       tx_irq;
        logic       err_irq;
        logic       rx_dma;
        logic       tx_dma;
        logic [2:0] live;
    } req_out_s;
endpackage

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
    parameter int WORD_BASE = 7,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    word_len,
    input  logic          bit_tick,
    input  logic          rx_push,
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] rx_thr,
    output logic          fire
);
    localparam int MAXLIM = 3 * (WORD_BASE + 3);
    localparam int TW     = $clog2(MAXLIM + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          fired;
    } to_s;

    to_s           s_d, s_q;
    logic [TW-1:0] lim;

    assign lim = TW'(3 * (WORD_BASE + int'(word_len)));

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (!fifo_en || rx_push || rx_level == '0) begin
            s_d.cnt   = '0;
            s_d.fired = 1'b0;
        end else if (bit_tick && !s_q.fired && rx_level < rx_thr) begin
            if (s_q.cnt == lim - TW'(1)) begin
                fire      = 1'b1;
                s_d.fired = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uirq_errstat.sv
module uirq_errstat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] new_err,
    input  logic       err_rd,
    output logic [3:0] err_q
);
    logic [3:0] err_d;

    always_comb begin
        if (err_rd) err_d = new_err;
        else        err_d = err_q | new_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end
endmodule

// File: rtl/uirq_irq_gen.sv
module uirq_irq_gen
    import uirq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WORD_BASE = 7,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    rx_mode,
    input  logic [1:0]    tx_mode,
    input  logic [1:0]    rx_trig,
    input  logic [1:0]    tx_trig,
    input  logic [1:0]    word_len,
    input  logic          err_ie,
    input  logic          bit_tick,
    input  logic          rx_push,
    input  logic [CW-1:0] rx_level,
    input  logic          par_err,
    input  logic          frm_err,
    input  logic          brk_det,
    input  logic          tx_pop,
    input  logic [CW-1:0] tx_level,
    input  logic          tx_shift_empty,
    input  logic          err_rd,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          err_irq,
    output logic          rx_dma,
    output logic          tx_dma,
    output logic [6:0]    stat
);
    function automatic logic [CW-1:0] thr_of(input logic [1:0] code);
        case (code)
            2'd0:    return CW'(1);
            2'd1:    return CW'(DEPTH / 4);
            2'd2:    return CW'(DEPTH / 2);
            default: return CW'((3 * DEPTH) / 4);
        endcase
    endfunction

    req_out_s      s_d, s_q;
    logic [CW-1:0] rx_thr, tx_thr, cap;
    logic [3:0]    new_err;
    logic [3:0]    err_q;
    logic          to_fire, rx_evt, tx_evt, ovr;

    assign rx_thr = thr_of(rx_trig);
    assign tx_thr = thr_of(tx_trig);
    assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
    assign ovr    = rx_push && (rx_level == cap);
    assign new_err = {brk_det, frm_err, par_err, ovr};

    uirq_timeout #(.WORD_BASE(WORD_BASE), .CW(CW)) u_to (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .word_len (word_len),
        .bit_tick (bit_tick),
        .rx_push  (rx_push),
        .rx_level (rx_level),
        .rx_thr   (rx_thr),
        .fire     (to_fire)
    );

    uirq_errstat u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_err (new_err),
        .err_rd  (err_rd),
        .err_q   (err_q)
    );

    always_comb begin
        if (fifo_en) begin
            rx_evt = (rx_push && (rx_level + CW'(1) == rx_thr)) || to_fire;
            tx_evt = tx_pop && (tx_level != '0) && (tx_level - CW'(1) == tx_thr);
        end else begin
            rx_evt = rx_push;
            tx_evt = tx_pop;
        end
        s_d         = '0;
        s_d.rx_irq  = rx_evt && (rx_mode == MODE_IRQ);
        s_d.rx_dma  = rx_evt && (rx_mode == MODE_DMA);
        s_d.tx_irq  = tx_evt && (tx_mode == MODE_IRQ);
        s_d.tx_dma  = tx_evt && (tx_mode == MODE_DMA);
        s_d.err_irq = err_ie && (new_err != 4'b0);
        s_d.live    = {tx_shift_empty, tx_level == '0, rx_level != '0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_irq  = s_q.rx_irq;
    assign tx_irq  = s_q.tx_irq;
    assign err_irq = s_q.err_irq;
    assign rx_dma  = s_q.rx_dma;
    assign tx_dma  = s_q.tx_dma;
    assign stat    = {s_q.live, err_q};
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic [1:0] rx_mode,
    input logic [1:0] tx_mode,
    input logic       err_ie,
    input logic       rx_push,
    input logic       par_err,
    input logic       tx_pop,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       err_irq,
    input logic       rx_dma,
    input logic       tx_dma,
    input logic [6:0] stat
);
    // R11: routing follows the mode seen in the cause cycle
    a_r11_rx_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(rx_mode) == 2'b01);
    a_r11_rx_dma_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma |-> $past(rx_mode) == 2'b10);
    a_r11_tx_dma_mode: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma |-> $past(tx_mode) == 2'b10);
    // R5: no error pulse without enable
    a_r5_err_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(err_ie));
    // R9 / R10: transmit requests only follow a pop
    a_r10_tx_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq || tx_dma) |-> $past(tx_pop));
    // R8: without FIFOs a receive request needs a push
    a_r8_nofifo_rx_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq || rx_dma) |-> ($past(fifo_en) || $past(rx_push)));
    // R3: parity status bit only rises after a parity strobe
    a_r3_parity_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(par_err));
endmodule

bind uirq_irq_gen uirq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .rx_mode (rx_mode),
    .tx_mode (tx_mode),
    .err_ie  (err_ie),
    .rx_push (rx_push),
    .par_err (par_err),
    .tx_pop  (tx_pop),
    .rx_irq  (rx_irq),
    .tx_irq  (tx_irq),
    .err_irq (err_irq),
    .rx_dma  (rx_dma),
    .tx_dma  (tx_dma),
    .stat    (stat)
);

// File: tb/tb_uirq_irq_gen.sv
`timescale 1ns/1ps
module tb_uirq_irq_gen;
    localparam int DEPTH = 16;
    localparam int WB    = 7;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, err_ie = 1'b0, bit_tick = 1'b0, rx_push = 1'b0;
    logic [1:0] rx_mode = '0, tx_mode = '0, rx_trig = '0, tx_trig = '0, word_len = '0;
    logic [CW-1:0] rx_level = '0, tx_level = '0;
    logic par_err = 1'b0, frm_err = 1'b0, brk_det = 1'b0, tx_pop = 1'b0;
    logic tx_shift_empty = 1'b0, err_rd = 1'b0;
    logic rx_irq, tx_irq, err_irq, rx_dma, tx_dma;
    logic [6:0] stat;

    always #2.5 clk = ~clk;

    uirq_irq_gen #(.DEPTH(DEPTH), .WORD_BASE(WB)) dut (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int m_cnt = 0;
    bit m_fired = 1'b0;
    logic [3:0] m_err = '0;
    int rx_pulses = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int thr(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return 3 * DEPTH / 4;
        endcase
    endfunction

    // inputs already driven at a negedge; model, clock, compare
    task automatic step();
        int cap, lvl, txl, lim, rt;
        bit ovr, fire, rx_evt, tx_evt;
        logic [3:0] ne;
        logic [6:0] es;
        cap = fifo_en ? DEPTH : 1;
        lvl = int'(rx_level);
        txl = int'(tx_level);
        rt  = thr(rx_trig);
        lim = 3 * (WB + int'(word_len));
        ovr = rx_push && (lvl == cap);
        ne  = {brk_det, frm_err, par_err, ovr};
        fire = 1'b0;
        if (!fifo_en || rx_push || lvl == 0) begin
            m_cnt = 0; m_fired = 1'b0;
        end else if (bit_tick && !m_fired && lvl < rt) begin
            if (m_cnt == lim - 1) begin fire = 1'b1; m_fired = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        if (fifo_en) begin
            rx_evt = (rx_push && (lvl + 1 == rt)) || fire;
            tx_evt = tx_pop && txl != 0 && (txl - 1 == thr(tx_trig));
        end else begin
            rx_evt = rx_push;
            tx_evt = tx_pop;
        end
        m_err = err_rd ? ne : (m_err | ne);
        es = {tx_shift_empty, txl == 0, lvl != 0, m_err};
        @(posedge clk);
        @(negedge clk);
        if (rx_irq) rx_pulses++;
        check(rx_irq == (rx_evt && rx_mode == 2'b01),
              fifo_en ? (fire ? "R7 rx_irq timeout" : "R6 rx_irq") : "R8 rx_irq",
              rx_irq, rx_evt && rx_mode == 2'b01);
        check(rx_dma == (rx_evt && rx_mode == 2'b10), "R11 rx_dma", rx_dma,
              rx_evt && rx_mode == 2'b10);
        check(tx_irq == (tx_evt && tx_mode == 2'b01), fifo_en ? "R9 tx_irq" : "R10 tx_irq",
              tx_irq, tx_evt && tx_mode == 2'b01);
        check(tx_dma == (tx_evt && tx_mode == 2'b10), "R11 tx_dma", tx_dma,
              tx_evt && tx_mode == 2'b10);
        check(err_irq == (err_ie && ne != 0), "R5 err_irq", err_irq, err_ie && ne != 0);
        check(stat[3:0] == es[3:0], ovr ? "R4 overrun status" : "R3 error status",
              stat[3:0], es[3:0]);
        check(stat[6:4] == es[6:4], "R2 live status", stat[6:4], es[6:4]);
    endtask

    task automatic idle_inputs();
        bit_tick = 0; rx_push = 0; par_err = 0; frm_err = 0; brk_det = 0;
        tx_pop = 0; err_rd = 0;
    endtask

    initial begin
        int rxl, txl, cap, push_div;
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0;
        tx_shift_empty = 1'b1; rx_push = 1'b1; par_err = 1'b1; err_ie = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs held low in reset despite active inputs
        check({rx_irq, tx_irq, err_irq, rx_dma, tx_dma, stat} == 0, "R1 reset outputs",
              {rx_irq, tx_irq, err_irq, rx_dma, tx_dma, stat}, 0);
        idle_inputs();
        err_ie = 0;
        @(negedge clk);
        rst_n = 1'b1;

        // directed R7: timeout after 21 ticks, exactly once
        fifo_en = 1; rx_mode = 2'b01; rx_trig = 2'd1; word_len = 2'd0;
        rx_level = CW'(2); tx_level = CW'(3);
        rx_pulses = 0;
        for (int i = 0; i < 60; i++) begin
            bit_tick = 1'b1;
            step();
            if (i == 20) check(rx_irq == 1'b1, "R7 timeout on 21st tick", rx_irq, 1);
        end
        check(rx_pulses == 1, "R7 single timeout pulse", rx_pulses, 1);
        idle_inputs();

        // directed R4 + R3 read clear
        rx_level = CW'(DEPTH); rx_push = 1; step(); rx_push = 0;
        check(stat[0] == 1'b1, "R4 overrun at full", stat[0], 1);
        err_rd = 1; step(); err_rd = 0;
        check(stat[3:0] == 0, "R3 read clears", stat[3:0], 0);
        // R5: simultaneous errors, one pulse
        err_ie = 1; par_err = 1; frm_err = 1; brk_det = 1; step(); idle_inputs();
        check(err_irq == 1'b1, "R5 one pulse for three errors", err_irq, 1);
        step();
        check(err_irq == 1'b0, "R5 pulse lasts one cycle", err_irq, 0);

        // constrained random phases
        rxl = 0; txl = 0;
        for (int ph = 0; ph < 10; ph++) begin
            fifo_en  = (ph % 3 != 2);
            rx_mode  = 2'($urandom_range(3));
            tx_mode  = 2'($urandom_range(3));
            rx_trig  = 2'($urandom_range(3));
            tx_trig  = 2'($urandom_range(3));
            word_len = 2'($urandom_range(3));
            err_ie   = 1'($urandom_range(1));
            push_div = (ph % 2 == 0) ? 6 : 64;
            cap = fifo_en ? DEPTH : 1;
            if (rxl > cap) rxl = cap;
            if (txl > cap) txl = cap;
            for (int c = 0; c < 1800; c++) begin
                bit t;
                rx_level = CW'(rxl); tx_level = CW'(txl);
                bit_tick = ($urandom_range(1) == 1);
                rx_push  = ($urandom_range(push_div - 1) == 0);
                tx_pop   = (txl > 0) && ($urandom_range(5) == 0);
                par_err  = ($urandom_range(39) == 0);
                frm_err  = ($urandom_range(39) == 0);
                brk_det  = ($urandom_range(59) == 0);
                err_rd   = ($urandom_range(15) == 0);
                tx_shift_empty = 1'($urandom_range(1));
                step();
                t = ($urandom_range(push_div * 2) == 0);
                if (rx_push && rxl < cap) rxl++;
                else if (!rx_push && t && rxl > 0) rxl--;
                if (tx_pop) txl--;
                else if (txl < cap && $urandom_range(7) == 0) txl++;
            end
        end
        idle_inputs();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule